// File: doc/BRIEF.md
# Address Range Attribute Bank

This block keeps a small table of physical address windows, each tagged with attribute bits such as "speculative access allowed". Software sets up the table through two CSR-style registers: a selector register that picks one of the table entries, and a data register that reads or writes the selected entry. Each window uses two entries. The even entry holds the top of the window and the odd entry holds the bottom. Both bounds are stored at 64 KiB granularity. A window takes part in matching only after both of its entries have been marked valid.

A lookup stream carries physical addresses into the block. Each address is compared against every window at the same time. Where several windows cover the address, the window with the lowest number supplies the attributes. The result is returned one cycle after the request is accepted, on a response stream with a hit flag. Both streams use a valid/ready handshake. A request is accepted only when the response slot is free, or when the slot is being emptied in that same cycle. A response that is not taken stays unchanged on the outputs until `rsp_ready` is seen high. The CSR pins are plain: a write strobe, a register select and combinational read data.

Top module: `addr_attr_bank`

## Requirements
- R1: With `csr_sel`=0, a write of a value below 2*NUM_PAIRS loads the selector. A write of any larger value leaves the selector unchanged. A read with `csr_sel`=0 returns the selector, zero-extended.
- R2: With `csr_sel`=1, a write stores into the selected entry only these fields: address in bits 31:12, attributes in bits ATTR_W:1, valid in bit 0. A read returns the selected entry, and all other bits read zero.
- R3: After reset the selector is 0, every entry reads 0, and every lookup misses.
- R4: Window k uses entry 2k as its upper bound and entry 2k+1 as its lower bound. Entry bits 31:12 hold physical address bits 35:16, so entry bit 12 carries address bit 16.
- R5: A window covers address A when `{lo[31:12],16'h0000}` <= A <= `{up[31:12],16'hFFFF}`. Both ends are included.
- R6: A window matches only if bit 0 is set in both of its entries.
- R7: When several windows match, the lowest-numbered one wins. Its attributes come from bits ATTR_W:1 of its lower-bound entry, where bit 1 is the speculative-access flag.
- R8: An accepted request (`lk_valid` and `lk_ready` both high) produces `rsp_valid` on the next cycle. Without an accepted request, and with the response taken, `rsp_valid` drops.
- R9: `lk_ready` is low exactly when a response is waiting and `rsp_ready` is low. While waiting, `rsp_hit` and `rsp_attr` hold their values.
- R10: A response with `rsp_hit`=0 carries `rsp_attr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 1 | 0 selects the selector register, 1 selects the data register |
| csr_wdata | input | REG_W | CSR write data |
| csr_rdata | output | REG_W | CSR read data (combinational) |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_addr | input | REG_W+4 | Physical address to classify |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_hit | output | 1 | Some active window covers the address |
| rsp_attr | output | ATTR_W | Attributes of the winning window |

## Verification
The assertions check the stream rules on every cycle: the one-cycle response timing, holding of the response under back-pressure, the ready rule, zero attributes on a miss, the selector range and zero reserved read bits. Only the bench's scenarios can show the range arithmetic. These scenarios are each window's lower bound, the address just below it, its upper bound and the address just above it. They also cover overlap priority, windows that are half valid, the window that ends at the top of the address space, field placement in the entries, and ignored selector writes. A scoreboard compares each response with the result predicted from the programmed window list.

// File: rtl/aab_pkg.sv
package aab_pkg;
  localparam int FIELD_LSB  = 12;  // entry bit holding address bit GRAN_BITS
  localparam int ADDR_SHIFT = 4;   // address is stored right-shifted by this
  localparam int GRAN_BITS  = 16;  // 64 KiB granule
  localparam int VALID_BIT  = 0;
endpackage

// File: rtl/aab_regfile.sv
module aab_regfile
  import aab_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int REG_W     = 32,
  parameter int ATTR_W    = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                csr_we,
  input  logic                                csr_sel,
  input  logic [REG_W-1:0]                    csr_wdata,
  output logic [REG_W-1:0]                    csr_rdata,
  output logic [2*NUM_PAIRS-1:0][REG_W-1:0]   regs_o
);
  localparam int NREG  = 2 * NUM_PAIRS;
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [REG_W-1:0] LOW_MASK  = REG_W'((64'd1 << (ATTR_W + 1)) - 64'd1);
  localparam logic [REG_W-1:0] WMASK     = ({REG_W{1'b1}} << FIELD_LSB) | LOW_MASK;

  logic [IDX_W-1:0] idx_q;
  logic [NREG-1:0][REG_W-1:0] regs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      regs_q <= '0;
    end else if (csr_we) begin
      if (!csr_sel) begin
        if (csr_wdata < REG_W'(NREG)) idx_q <= csr_wdata[IDX_W-1:0];
      end else begin
        regs_q[idx_q] <= csr_wdata & WMASK;
      end
    end
  end

  assign csr_rdata = csr_sel ? regs_q[idx_q] : REG_W'(idx_q);
  assign regs_o    = regs_q;
endmodule

// File: rtl/aab_range_cmp.sv
module aab_range_cmp
  import aab_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ATTR_W = 2
) (
  input  logic [REG_W-1:0]           upper_reg,
  input  logic [REG_W-1:0]           lower_reg,
  input  logic [REG_W-FIELD_LSB-1:0] addr_fld,
  output logic                       match,
  output logic [ATTR_W-1:0]          attr
);
  logic active, above_lo, below_up;

  assign active   = upper_reg[VALID_BIT] & lower_reg[VALID_BIT];
  assign above_lo = addr_fld >= lower_reg[REG_W-1:FIELD_LSB];
  assign below_up = addr_fld <= upper_reg[REG_W-1:FIELD_LSB];
  assign match    = active & above_lo & below_up;
  assign attr     = lower_reg[ATTR_W:1];
endmodule

// File: rtl/aab_pick.sv
module aab_pick #(
  parameter int NUM_PAIRS = 8,
  parameter int ATTR_W    = 2
) (
  input  logic [NUM_PAIRS-1:0]             match,
  input  logic [NUM_PAIRS-1:0][ATTR_W-1:0] attr_in,
  output logic                             hit,
  output logic [ATTR_W-1:0]                attr_out
);
  always_comb begin
    hit      = 1'b0;
    attr_out = '0;
    for (int k = NUM_PAIRS - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit      = 1'b1;
        attr_out = attr_in[k];
      end
    end
  end
endmodule

// File: rtl/addr_attr_bank.sv
module addr_attr_bank
  import aab_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int REG_W     = 32,
  parameter int ATTR_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        csr_we,
  input  logic                        csr_sel,
  input  logic [REG_W-1:0]            csr_wdata,
  output logic [REG_W-1:0]            csr_rdata,
  input  logic                        lk_valid,
  output logic                        lk_ready,
  input  logic [REG_W+ADDR_SHIFT-1:0] lk_addr,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic                        rsp_hit,
  output logic [ATTR_W-1:0]           rsp_attr
);
  localparam int PA_W  = REG_W + ADDR_SHIFT;
  localparam int FLD_W = REG_W - FIELD_LSB;

  logic [2*NUM_PAIRS-1:0][REG_W-1:0] regs;
  logic [NUM_PAIRS-1:0]              pair_match;
  logic [NUM_PAIRS-1:0][ATTR_W-1:0]  pair_attr;
  logic                              sel_hit;
  logic [ATTR_W-1:0]                 sel_attr;
  logic [FLD_W-1:0]                  addr_fld;

  aab_regfile #(.NUM_PAIRS(NUM_PAIRS), .REG_W(REG_W), .ATTR_W(ATTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .regs_o(regs)
  );

  assign addr_fld = lk_addr[PA_W-1:GRAN_BITS];

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    aab_range_cmp #(.REG_W(REG_W), .ATTR_W(ATTR_W)) u_cmp (
      .upper_reg(regs[2*k]), .lower_reg(regs[2*k+1]), .addr_fld(addr_fld),
      .match(pair_match[k]), .attr(pair_attr[k])
    );
  end

  aab_pick #(.NUM_PAIRS(NUM_PAIRS), .ATTR_W(ATTR_W)) u_pick (
    .match(pair_match), .attr_in(pair_attr), .hit(sel_hit), .attr_out(sel_attr)
  );

  assign lk_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_attr  <= '0;
    end else if (lk_valid && lk_ready) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= sel_hit;
      rsp_attr  <= sel_attr;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/aab_checker.sv
module aab_checker #(
  parameter int NUM_PAIRS = 8,
  parameter int REG_W     = 32,
  parameter int ATTR_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_sel,
  input logic [REG_W-1:0]  csr_rdata,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [ATTR_W-1:0] rsp_attr
);
  p_sel_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_sel |-> csr_rdata < REG_W'(2 * NUM_PAIRS));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_sel |-> csr_rdata[11:ATTR_W+1] == '0);

  p_resp_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  p_resp_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lk_valid && lk_ready) && rsp_ready) |=> !rsp_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_attr));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lk_ready);

  p_miss_attr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_attr == '0);
endmodule

bind addr_attr_bank aab_checker #(.NUM_PAIRS(NUM_PAIRS), .REG_W(REG_W), .ATTR_W(ATTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_rdata(csr_rdata),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_attr(rsp_attr)
);

// File: tb/sim_addr_attr_bank.sv
module sim_addr_attr_bank;
  localparam int N  = 8;
  localparam int RW = 32;
  localparam int AW = 2;
  localparam int PW = RW + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0, csr_sel = 1'b0;
  logic [RW-1:0] csr_wdata = '0, csr_rdata;
  logic lk_valid = 1'b0, lk_ready;
  logic [PW-1:0] lk_addr = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_hit;
  logic [AW-1:0] rsp_attr;

  int checks = 0, fails = 0;
  bit bp = 0;
  bit done = 0;
  logic [AW:0] expq[$];
  logic [RW-1:0] mreg [2*N];
  logic [PW-1:0] lo_pa [N], up_pa [N];
  bit used [N];

  always #5 clk = ~clk;

  addr_attr_bank #(.NUM_PAIRS(N), .REG_W(RW), .ATTR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_attr(rsp_attr)
  );

  function automatic logic [RW-1:0] enc(logic [PW-1:0] pa, logic [AW-1:0] at, logic v);
    logic [PW-1:0] sh;
    sh = pa >> 4;
    return (sh[RW-1:0] & 32'hFFFF_F000) | (RW'(at) << 1) | RW'(v);
  endfunction

  // R5 R6 R7 R10 reference prediction
  function automatic logic [AW:0] predict(logic [PW-1:0] a);
    for (int k = 0; k < N; k++) begin
      logic [RW-1:0] up, lo;
      up = mreg[2*k]; lo = mreg[2*k+1];
      if (up[0] && lo[0] && a[PW-1:16] >= lo[RW-1:12] && a[PW-1:16] <= up[RW-1:12])
        return {1'b1, lo[AW:1]};
    end
    return '0;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic csr_wr(logic sel, logic [RW-1:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(logic sel, logic [RW-1:0] exp_v, string req);
    @(negedge clk);
    csr_sel = sel;
    #1;
    check(req, 64'(csr_rdata), 64'(exp_v));
  endtask

  task automatic prog(int k, logic [PW-1:0] lo, logic [PW-1:0] up, logic [AW-1:0] at,
                      logic vup, logic vlo);
    csr_wr(1'b0, RW'(2*k));
    csr_wr(1'b1, enc(up, at, vup));
    mreg[2*k] = enc(up, at, vup);
    csr_wr(1'b0, RW'(2*k+1));
    csr_wr(1'b1, enc(lo, at, vlo));
    mreg[2*k+1] = enc(lo, at, vlo);
    lo_pa[k] = lo; up_pa[k] = up; used[k] = 1;
  endtask

  // driver: pushes prediction, then offers the request until accepted
  task automatic lookup(logic [PW-1:0] a);
    expq.push_back(predict(a));
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    #1;
    while (!lk_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic sweep_bounds();
    for (int k = 0; k < N; k++) begin
      if (used[k]) begin
        logic [PW:0] above;
        lookup(lo_pa[k]);
        if (lo_pa[k] != '0) lookup(lo_pa[k] - 1'b1);
        lookup(up_pa[k]);
        above = {1'b0, up_pa[k]} + 1'b1;
        if (!above[PW]) lookup(above[PW-1:0]);
      end
    end
  endtask

  // monitor: drives back-pressure and scores every taken response
  always begin
    @(negedge clk);
    rsp_ready <= bp ? 1'($urandom_range(0, 1)) : 1'b1;
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) begin
        check("R8 unexpected response", 64'(1), 64'(0));
      end else begin
        logic [AW:0] e;
        e = expq.pop_front();
        check("R5/R6/R7/R10 lookup", 64'({rsp_hit, rsp_attr}), 64'(e));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2*N; i++) mreg[i] = '0;
    for (int k = 0; k < N; k++) used[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    csr_rd(1'b0, '0, "R3 selector after reset");
    check("R3 no response after reset", 64'(rsp_valid), 64'(0));
    for (int i = 0; i < 2*N; i++) begin
      csr_wr(1'b0, RW'(i));
      csr_rd(1'b1, '0, "R3 entry after reset");
    end
    lookup('0);
    lookup(36'h8_0000_1234);

    // R1 selector writes
    csr_wr(1'b0, 32'd3);
    csr_rd(1'b0, 32'd3, "R1 selector load");
    csr_wr(1'b0, RW'(2*N));
    csr_rd(1'b0, 32'd3, "R1 out-of-range ignored");
    csr_wr(1'b0, 32'hFFFF_FFFF);
    csr_rd(1'b0, 32'd3, "R1 large value ignored");

    // R2 field masking
    csr_wr(1'b1, 32'hFFFF_FFFF);
    csr_rd(1'b1, 32'hFFFF_F007, "R2 masked readback");
    csr_wr(1'b1, 32'h0000_0FF8);
    csr_rd(1'b1, 32'h0000_0000, "R2 reserved bits drop");

    // R4 field placement: address bit 16 lands in entry bit 12
    csr_wr(1'b0, 32'd5);
    csr_wr(1'b1, enc(36'h0_0001_0000, 2'b00, 1'b1));
    csr_rd(1'b1, 32'h0000_1001, "R4 field position");
    csr_wr(1'b1, 32'h0);

    // windows (R4 even=upper, odd=lower)
    prog(0, 36'h0_0001_0000, 36'h0_0003_FFFF, 2'b01, 1'b1, 1'b1);
    prog(1, 36'h0_0002_0000, 36'h0_0005_FFFF, 2'b10, 1'b1, 1'b1);
    prog(2, 36'h1_0000_0000, 36'h1_000F_FFFF, 2'b11, 1'b1, 1'b0); // R6 half valid
    prog(3, 36'hF_FFF0_0000, 36'hF_FFFF_FFFF, 2'b11, 1'b1, 1'b1);
    prog(4, 36'h0_0000_0000, 36'h0_0000_FFFF, 2'b00, 1'b1, 1'b1);
    prog(7, 36'h8_0000_0000, 36'h8_0000_FFFF, 2'b10, 1'b1, 1'b1);
    csr_wr(1'b0, 32'd3);
    csr_rd(1'b1, enc(36'h0_0002_0000, 2'b10, 1'b1), "R4 lower of window 1 at odd entry");

    sweep_bounds();          // R5 boundaries, R7 overlap at 0x2_0000
    lookup(36'h0_0002_8000); // R7 overlap interior
    lookup(36'h1_0008_0000); // R6 half-valid window

    bp = 1;                  // R9 back-pressure
    sweep_bounds();
    for (int i = 0; i < 20; i++) lookup(36'h0_0001_0000 + 36'(i) * 36'h1_0000);

    prog(0, 36'h0_0001_0000, 36'h0_0003_FFFF, 2'b01, 1'b1, 1'b0); // R6 drop lower valid
    prog(2, 36'h1_0000_0000, 36'h1_000F_FFFF, 2'b11, 1'b0, 1'b1); // R6 upper invalid
    sweep_bounds();
    prog(2, 36'h1_0000_0000, 36'h1_000F_FFFF, 2'b11, 1'b1, 1'b1);
    sweep_bounds();

    bp = 0;
    repeat (20) @(negedge clk);
    check("R8 all responses delivered", 64'(expq.size()), 64'(0));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule